// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the digital control core of a half-bridge power stage. It receives already-digitized inputs:

- a three-level PWM command, given as one-hot high, mid and low flags;
- an active-low stage disable;
- an active-low zero-current mode enable and a zero-cross comparator flag;
- gate-off sense flags for both switches;
- a thermal shutdown request.

From these it produces the high-side and low-side gate enables, plus a calibration-busy flag. Every delay is counted in cycles of a single clock.

The sequencer is one finite-state machine. The states are:

- `ST_DISABLED`: stage disabled, both gates off.
- `ST_CAL`: zero-cross threshold calibration, both gates off, busy high.
- `ST_SAFE`: thermal shutdown, both gates off.
- `ST_IDLE`: both gates off, waiting for a high or low PWM command.
- `ST_TO_HS`: low side released, dead time running toward the high side.
- `ST_HS_ON`: high side driven.
- `ST_TO_LS`: high side released, dead time running toward the low side.
- `ST_LS_ON`: low side driven, blanking window running.
- `ST_LS_ZC`: low side turned off by zero-cross detection.

Transitions by trigger:

- Disable low moves any state to `ST_DISABLED`.
- A rising disable moves any state to `ST_CAL`.
- Thermal shutdown moves any state except `ST_CAL` to `ST_SAFE`.
- `ST_CAL` goes to `ST_IDLE` when its count ends, and `ST_SAFE` goes to `ST_IDLE` once the thermal request clears.
- A high PWM moves `ST_IDLE`, `ST_TO_LS`, `ST_LS_ON` or `ST_LS_ZC` to `ST_TO_HS`.
- A low PWM moves `ST_IDLE`, `ST_TO_HS` or `ST_HS_ON` to `ST_TO_LS`.
- `ST_TO_HS` goes to `ST_HS_ON` after the dead time has elapsed with the low side sensed off. `ST_TO_LS` goes to `ST_LS_ON` the same way, with the high side sensed off.
- In zero-current mode, `ST_LS_ON` goes to `ST_LS_ZC` on a zero-cross once blanking has ended.
- An expired mid-level holdoff moves any switching state to `ST_IDLE`.

Top module: `gate_seq_core`

## Requirements
- R1: While `rst_n` is low, and one clock edge after `dis_n` is sampled low, `hs_en`, `ls_en` and `cal_busy` are all 0.
- R2: After `pwm_hi` is sampled, `ls_en` is 0 from the next edge. `hs_en` rises only once `ls_off_sense` has been high for `DEAD_HS_CYC` counted edges; with sense already high, `hs_en` is 1 on the (`DEAD_HS_CYC`+2)th edge after the command.
- R3: After `pwm_lo` is sampled, `hs_en` is 0 from the next edge. With `hs_off_sense` high, `ls_en` is 1 on the (`DEAD_LS_CYC`+2)th edge.
- R4: `hs_en` and `ls_en` are never both 1 in any cycle.
- R5: With `zc_en_n`=1, `ls_en` stays on while PWM stays low, whatever `zc_det` does.
- R6: With `zc_en_n`=0, `ls_en` stays on for `BLANK_CYC`+1 edges after it rises. It then drops on the first edge at which `zc_det` is sampled high, and stays off until PWM goes high.
- R7: `pwm_mid` held for `HOLD_CYC` consecutive edges forces both gates off on the next edge.
- R8: A return to `pwm_hi` or `pwm_lo` before the holdoff count completes clears the count and leaves switching undisturbed.
- R9: Each 0-to-1 transition of `dis_n`, including the first one after reset, raises `cal_busy` on the next edge for `CAL_CYC`+1 cycles with both gates off. Switching resumes only after that.
- R10: `ot_shdn` high forces both gates off on the next edge. After it clears, sequencing restarts from idle.
- R11: While the opposite gate's off-sense flag is low, the dead-time count does not advance and the pending gate stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | 1 | PWM decoded at high level |
| pwm_mid | input | 1 | PWM decoded at mid level |
| pwm_lo | input | 1 | PWM decoded at low level |
| dis_n | input | 1 | Active-low stage disable |
| zc_en_n | input | 1 | Active-low zero-current mode enable |
| zc_det | input | 1 | Zero-cross comparator flag |
| ls_off_sense | input | 1 | Low-side gate sensed off |
| hs_off_sense | input | 1 | High-side gate sensed off |
| ot_shdn | input | 1 | Thermal shutdown request |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| cal_busy | output | 1 | Calibration in progress |

## Verification
The sequencer is exercised with these PWM patterns:

- low-to-high and high-to-low edges with off-sense already high, which measures the dead time exactly;
- a high command while low-side sense is held low, which shows the count is gated by sense rather than free-running;
- low phases with the zero-current mode on and off while the comparator flag is high, which separates the blanking plus zero-cross turn-off from plain following;
- a mid level held past the holdoff, compared with one that returns early, which separates expiry from cancellation.

Disable pulses and thermal requests arrive mid-switching, and the first enable after reset is timed through the whole calibration to the first gate turn-on.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
    typedef enum logic [3:0] {
        ST_DISABLED,
        ST_CAL,
        ST_SAFE,
        ST_IDLE,
        ST_TO_HS,
        ST_HS_ON,
        ST_TO_LS,
        ST_LS_ON,
        ST_LS_ZC
    } seq_state_t;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R11: the count never moves without run
    a_r11_count_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt_q));
endmodule

// File: rtl/mid_holdoff.sv
module mid_holdoff #(
    parameter int unsigned HOLD_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_mid,
    output logic hold_hit
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1) + 1;
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);

    logic [HW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (!pwm_mid)
            run_q <= '0;
        else if (run_q != HOLD_V)
            run_q <= run_q + 1'b1;
    end

    assign hold_hit = (run_q == HOLD_V);

    a_r7_hit_after_mid: assert property (@(posedge clk) disable iff (!rst_n)
        hold_hit |-> $past(pwm_mid));
    a_r8_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_mid |=> !hold_hit);
endmodule

// File: rtl/gate_seq_core.sv
module gate_seq_core
    import gate_seq_pkg::*;
#(
    parameter int unsigned DEAD_HS_CYC = 3,
    parameter int unsigned DEAD_LS_CYC = 3,
    parameter int unsigned BLANK_CYC   = 25,
    parameter int unsigned HOLD_CYC    = 25,
    parameter int unsigned CAL_CYC     = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic pwm_mid,
    input  logic pwm_lo,
    input  logic dis_n,
    input  logic zc_en_n,
    input  logic zc_det,
    input  logic ls_off_sense,
    input  logic hs_off_sense,
    input  logic ot_shdn,
    output logic hs_en,
    output logic ls_en,
    output logic cal_busy
);
    localparam int unsigned MAXV = max2(max2(DEAD_HS_CYC, DEAD_LS_CYC),
                                        max2(max2(BLANK_CYC, HOLD_CYC), CAL_CYC));
    localparam int unsigned TW   = $clog2(MAXV + 1) + 1;

    seq_state_t    state_q, state_d;
    logic          dis_q;
    logic          dis_rise;
    logic          hold_hit;
    logic          tmr_zero;
    logic          tmr_load;
    logic          tmr_run;
    logic [TW-1:0] tmr_val;

    assign dis_rise = dis_n && !dis_q;

    mid_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_mid  (pwm_mid),
        .hold_hit (hold_hit)
    );

    seq_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .zero     (tmr_zero)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (!dis_n)
            state_d = ST_DISABLED;
        else if (dis_rise)
            state_d = ST_CAL;
        else if (ot_shdn && state_q != ST_CAL)
            state_d = ST_SAFE;
        else begin
            unique case (state_q)
                ST_DISABLED: state_d = ST_DISABLED;
                ST_CAL:      if (tmr_zero) state_d = ST_IDLE;
                ST_SAFE:     state_d = ST_IDLE;
                ST_IDLE: begin
                    if (pwm_hi)      state_d = ST_TO_HS;
                    else if (pwm_lo) state_d = ST_TO_LS;
                end
                ST_TO_HS: begin
                    if (hold_hit)                        state_d = ST_IDLE;
                    else if (pwm_lo)                     state_d = ST_TO_LS;
                    else if (tmr_zero && ls_off_sense)   state_d = ST_HS_ON;
                end
                ST_HS_ON: begin
                    if (hold_hit)    state_d = ST_IDLE;
                    else if (pwm_lo) state_d = ST_TO_LS;
                end
                ST_TO_LS: begin
                    if (hold_hit)                        state_d = ST_IDLE;
                    else if (pwm_hi)                     state_d = ST_TO_HS;
                    else if (tmr_zero && hs_off_sense)   state_d = ST_LS_ON;
                end
                ST_LS_ON: begin
                    if (hold_hit)                               state_d = ST_IDLE;
                    else if (pwm_hi)                            state_d = ST_TO_HS;
                    else if (!zc_en_n && tmr_zero && zc_det)    state_d = ST_LS_ZC;
                end
                ST_LS_ZC: begin
                    if (hold_hit)    state_d = ST_IDLE;
                    else if (pwm_hi) state_d = ST_TO_HS;
                end
                default: state_d = ST_DISABLED;
            endcase
        end
    end

    // shared timer control
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_TO_HS: tmr_val = TW'(DEAD_HS_CYC);
            ST_TO_LS: tmr_val = TW'(DEAD_LS_CYC);
            ST_LS_ON: tmr_val = TW'(BLANK_CYC);
            ST_CAL:   tmr_val = TW'(CAL_CYC);
            default:  tmr_val = '0;
        endcase
        tmr_run = (state_q == ST_TO_HS && ls_off_sense) ||
                  (state_q == ST_TO_LS && hs_off_sense) ||
                  (state_q == ST_LS_ON) || (state_q == ST_CAL);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DISABLED;
            dis_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dis_q   <= dis_n;
        end
    end

    // outputs, registered from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_en    <= 1'b0;
            ls_en    <= 1'b0;
            cal_busy <= 1'b0;
        end else begin
            hs_en    <= (state_d == ST_HS_ON);
            ls_en    <= (state_d == ST_LS_ON);
            cal_busy <= (state_d == ST_CAL);
        end
    end

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));
    a_r1_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_n |=> (!hs_en && !ls_en && !cal_busy));
    a_r10_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        ot_shdn |=> (!hs_en && !ls_en));
    a_r9_cal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (!hs_en && !ls_en));
    a_r2_hs_after_sense: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> ($past(!ls_en) && $past(ls_off_sense)));
    a_r3_ls_after_sense: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> ($past(!hs_en) && $past(hs_off_sense)));
endmodule

// File: tb/gate_seq_core_test.sv
module gate_seq_core_test;
    localparam int D_HS = 3;
    localparam int D_LS = 3;
    localparam int BLK  = 25;
    localparam int HLD  = 25;
    localparam int CAL  = 2500;

    logic clk = 1'b0;
    logic rst_n, pwm_hi, pwm_mid, pwm_lo, dis_n, zc_en_n, zc_det;
    logic ls_off_sense, hs_off_sense, ot_shdn;
    logic hs_en, ls_en, cal_busy;

    always #10 clk = ~clk;

    gate_seq_core #(
        .DEAD_HS_CYC(D_HS), .DEAD_LS_CYC(D_LS), .BLANK_CYC(BLK),
        .HOLD_CYC(HLD), .CAL_CYC(CAL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_mid(pwm_mid),
        .pwm_lo(pwm_lo), .dis_n(dis_n), .zc_en_n(zc_en_n), .zc_det(zc_det),
        .ls_off_sense(ls_off_sense), .hs_off_sense(hs_off_sense),
        .ot_shdn(ot_shdn), .hs_en(hs_en), .ls_en(ls_en), .cal_busy(cal_busy)
    );

    typedef struct {
        int    at;
        bit    hs;
        bit    ls;
        bit    busy;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t e;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   overlap = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected items as their cycle comes up
    always @(negedge clk) begin
        if (hs_en && ls_en) overlap++;
        while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            e = exp_q.pop_front();
            checks++;
            if (hs_en !== e.hs || ls_en !== e.ls || cal_busy !== e.busy) begin
                errors++;
                $display("FAIL %s cyc=%0d actual hs/ls/busy=%b%b%b expected=%b%b%b",
                         e.tag, cyc, hs_en, ls_en, cal_busy, e.hs, e.ls, e.busy);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int d, input bit hs, input bit ls,
                             input bit busy, input string tag);
        exp_t x;
        x.at = cyc + d; x.hs = hs; x.ls = ls; x.busy = busy; x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            report();
        end
    end

    initial begin
        rst_n = 0; dis_n = 0; pwm_lo = 1; pwm_hi = 0; pwm_mid = 0;
        zc_en_n = 1; zc_det = 0; ls_off_sense = 1; hs_off_sense = 1; ot_shdn = 0;
        step(3);
        rst_n = 1;
        expect_at(1, 0, 0, 0, "R1 reset state");
        step(2);

        // first enable: calibration, then low side
        dis_n = 1;
        expect_at(1, 0, 0, 1, "R9 busy starts");
        expect_at(CAL + 1, 0, 0, 1, "R9 busy last cycle");
        expect_at(CAL + 2, 0, 0, 0, "R9 busy ends");
        expect_at(CAL + D_LS + 3, 0, 0, 0, "R9 ls not yet");
        expect_at(CAL + D_LS + 4, 0, 1, 0, "R9 ls after cal");
        step(CAL + D_LS + 6);

        // plain mode ignores zero cross
        zc_det = 1;
        expect_at(BLK + 10, 0, 1, 0, "R5 ls held in plain mode");
        step(BLK + 12);

        // low to high
        pwm_lo = 0; pwm_hi = 1;
        expect_at(1, 0, 0, 0, "R2 ls released");
        expect_at(D_HS + 1, 0, 0, 0, "R2 hs dead time");
        expect_at(D_HS + 2, 1, 0, 0, "R2 hs on");
        step(D_HS + 5);
        zc_det = 0;

        // high to low
        pwm_hi = 0; pwm_lo = 1;
        expect_at(1, 0, 0, 0, "R3 hs released");
        expect_at(D_LS + 1, 0, 0, 0, "R3 ls dead time");
        expect_at(D_LS + 2, 0, 1, 0, "R3 ls on");
        step(D_LS + 5);

        // sense gating
        pwm_lo = 0; pwm_hi = 1; ls_off_sense = 0;
        expect_at(1, 0, 0, 0, "R11 ls released");
        expect_at(10, 0, 0, 0, "R11 hs waits for sense");
        step(10);
        ls_off_sense = 1;
        expect_at(D_HS, 0, 0, 0, "R11 count after sense");
        expect_at(D_HS + 1, 1, 0, 0, "R11 hs on after sense");
        step(D_HS + 4);

        // zero-current mode
        zc_en_n = 0; zc_det = 1; pwm_hi = 0; pwm_lo = 1;
        expect_at(D_LS + 2, 0, 1, 0, "R6 ls on");
        expect_at(D_LS + 2 + BLK, 0, 1, 0, "R6 blanking holds ls");
        expect_at(D_LS + 3 + BLK, 0, 0, 0, "R6 zero cross turns ls off");
        expect_at(D_LS + 8 + BLK, 0, 0, 0, "R6 ls stays off");
        step(D_LS + BLK + 10);
        pwm_lo = 0; pwm_hi = 1;
        expect_at(D_HS + 2, 1, 0, 0, "R6 hs after zero cross");
        step(D_HS + 4);
        zc_en_n = 1; zc_det = 0;

        // holdoff expiry
        pwm_hi = 0; pwm_mid = 1;
        expect_at(HLD, 1, 0, 0, "R7 hs before holdoff");
        expect_at(HLD + 1, 0, 0, 0, "R7 holdoff off");
        step(HLD + 4);
        pwm_mid = 0; pwm_hi = 1;
        expect_at(D_HS + 2, 1, 0, 0, "R7 resume after holdoff");
        step(D_HS + 4);

        // holdoff cancel
        pwm_hi = 0; pwm_mid = 1;
        step(HLD - 2);
        pwm_mid = 0; pwm_hi = 1;
        expect_at(1, 1, 0, 0, "R8 cancel keeps hs");
        expect_at(HLD + 5, 1, 0, 0, "R8 no late holdoff");
        step(HLD + 6);

        // thermal
        ot_shdn = 1;
        expect_at(1, 0, 0, 0, "R10 thermal off");
        step(5);
        ot_shdn = 0;
        expect_at(D_HS + 3, 1, 0, 0, "R10 restart after thermal");
        step(D_HS + 5);

        // disable and recalibration mid operation
        dis_n = 0;
        expect_at(1, 0, 0, 0, "R1 disable off");
        step(5);
        dis_n = 1;
        expect_at(1, 0, 0, 1, "R9 recal busy");
        expect_at(CAL + 2, 0, 0, 0, "R9 recal ends");
        expect_at(CAL + D_HS + 4, 1, 0, 0, "R9 hs after recal");
        step(CAL + D_HS + 6);

        checks++;
        if (overlap != 0) begin
            errors++;
            $display("FAIL R4 overlap cycles actual=%0d expected=0", overlap);
        end
        step(2);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL pending expectations actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        report();
    end
endmodule